// File: doc/BRIEF.md
# ATA Task File Register Block

This block is the device side of a legacy ATA register file as a host sees it over the parallel bus. The host selects a register with two active-low chip selects and three address lines. It then issues one-cycle read or write strobes that are synchronous to the block clock. The block keeps the command-block registers and the control register, and it answers reads with status, alternate status, error and a drive-address byte. Several addresses mean one register on a read and a different one on a write.

The device logic behind the block has a simple side interface. It can set and clear status bits, load the error byte and load the 16-bit data word. It gets a one-cycle strobe for each accepted command byte and for each data-word access by the host. It signals command completion to raise the interrupt line.

A hardware reset, or the software-reset bit in the control register, forces busy and reloads the defaults. Ready returns a programmable number of cycles after the reset ends. While busy is set, host writes to the command block are dropped, but writes to the control register are always accepted.

Top module: `ata_taskfile`

## Requirements
- R1: With chip select 0 low, chip select 1 high and address 000, reads and writes move the full 16-bit data word. Every other register reads back with bits 15..8 at zero, and a write to it uses only bits 7..0.
- R2: At address 001 (chip select 0 low), a read returns the error byte that the device loaded, and a write stores the write-precompensation byte on the `precomp` output without changing the error byte.
- R3: Addresses 010, 011, 100 and 101 (chip select 0 low) hold sector count, sector number, cylinder low byte and cylinder high bits. Only the two low bits of the cylinder high byte are kept, and they read back with bits 7..2 at zero.
- R4: Address 110 (chip select 0 low) holds the head in bits 3..0 and the drive select in bit 4 (0 master, 1 slave). Bits 7..5 always read 101, whatever was written.
- R5: A write to address 111 (chip select 0 low) holds `cmd_stb` high for exactly the next cycle, puts the byte on `cmd_code`, and sets status busy (bit 7).
- R6: Status bits are 0 error, 1 index, 2 corrected, 3 data request, 4 seek done, 5 write fault, 6 ready, 7 busy, and the device sets and clears them. A read at address 111 (chip select 0 low) returns status and drops the interrupt. A read at address 110 with chip select 1 low returns the same byte and leaves the interrupt unchanged.
- R7: A completion pulse from the device raises `irq` in the next cycle when control bit 1 (interrupt disable) is 0. When that bit is 1, the pulse leaves `irq` low.
- R8: Control bit 2 (chip select 1 low, address 110) is a software reset. While it is set, the block drops the interrupt, sets busy, clears ready, data request and error, zeroes the error byte and reloads the defaults. After a write clears the bit, busy stays set for READY_DELAY clock edges, counted from the edge of that write. Ready is set on the last of those edges.
- R9: After a hardware reset, status reads 0x80 with `irq` low, and sector count 1, sector number 1, cylinder 0, drive/head 0xA0 and error 0 are loaded. Status changes to 0x40 on the READY_DELAY-th edge after reset is released.
- R10: While busy is set, host writes to the command-block addresses have no effect. Writes to the control register still take effect.
- R11: A read at address 111 with chip select 1 low returns the drive-address byte. Bit 0 is 1 when the master is selected, bit 1 is 1 when the slave is selected, bits 5..2 are the complement of the head, bit 6 follows `dev_writing`, and bit 7 is 0.
- R12: Both chip selects low, both high, or chip select 1 low with an address below 110 selects nothing. Such a read returns 0 and such a write changes nothing.
- R13: A host write of the data word holds `data_wr_stb` high for one cycle and puts the word on `data_word`. A device load replaces the word the host reads. A host read of the data word holds `data_rd_stb` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| host_cs0_n | input | 1 | Command-block chip select, active low |
| host_cs1_n | input | 1 | Control-block chip select, active low |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| irq | output | 1 | Interrupt request to the host |
| soft_reset | output | 1 | Software-reset bit of the control register |
| dev_status_set | input | 8 | Status bits to set |
| dev_status_clr | input | 8 | Status bits to clear |
| dev_err_load | input | 1 | Load the error byte |
| dev_err_in | input | 8 | Error byte from the device |
| dev_data_load | input | 1 | Load the data word |
| dev_data_in | input | 16 | Data word from the device |
| dev_cmd_done | input | 1 | Command completion pulse |
| dev_writing | input | 1 | Write in progress flag |
| cmd_stb | output | 1 | Command byte accepted |
| cmd_code | output | 8 | Last accepted command byte |
| data_wr_stb | output | 1 | Host wrote the data word |
| data_rd_stb | output | 1 | Host read the data word |
| data_word | output | 16 | Current data word |
| precomp | output | 8 | Write-precompensation byte |
| sect_cnt | output | 8 | Sector count |
| sect_num | output | 8 | Sector number |
| cyl | output | CYL_W | Cylinder number |
| drv_sel | output | 1 | Drive select (1 = slave) |
| head | output | 4 | Head number |

## Verification
The bench targets the shared addresses. If the read and write meanings are swapped, the error byte shows the precompensation value or the precompensation output never updates. It contrasts primary and alternate status reads: a design that clears the interrupt on both loses a pending interrupt, and one that clears it on neither leaves the line stuck high. It issues writes while busy, including during a software reset, to catch a design that lets them through or that also blocks the control register. That second fault would make the reset impossible to release. It also counts the exact edge on which ready returns after both kinds of reset, and reads the fixed drive/head bits and the complemented head to expose an off-by-one delay and bit-ordering slips.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_ERRPC,
      SEL_SCNT,
      SEL_SNUM,
      SEL_CYLL,
      SEL_CYLH,
      SEL_DRVHD,
      SEL_CMDST,
      SEL_CTLALT,
      SEL_DRVADR
   } tf_sel_e;

   // status bit positions
   localparam int ST_ERR = 0;
   localparam int ST_DRQ = 3;
   localparam int ST_RDY = 6;
   localparam int ST_BSY = 7;

   // control bit positions
   localparam int CTL_NIEN = 1;
   localparam int CTL_SRST = 2;

   localparam logic [7:0] ST_RESET_CLR = (8'h1 << ST_RDY) | (8'h1 << ST_DRQ) | (8'h1 << ST_ERR);
   localparam logic [7:0] ST_HW_RESET  = 8'h1 << ST_BSY;
   localparam logic [2:0] DRVHD_FIXED  = 3'b101;
   localparam logic [7:0] DEF_SCNT     = 8'h01;
   localparam logic [7:0] DEF_SNUM     = 8'h01;

   // register decode: selects and address to register
   function automatic tf_sel_e tf_decode(input logic cs0_n, input logic cs1_n,
                                         input logic [2:0] addr);
      tf_sel_e s;
      s = SEL_NONE;
      if (!cs0_n && cs1_n) begin
         case (addr)
            3'd0:    s = SEL_DATA;
            3'd1:    s = SEL_ERRPC;
            3'd2:    s = SEL_SCNT;
            3'd3:    s = SEL_SNUM;
            3'd4:    s = SEL_CYLL;
            3'd5:    s = SEL_CYLH;
            3'd6:    s = SEL_DRVHD;
            default: s = SEL_CMDST;
         endcase
      end else if (cs0_n && !cs1_n) begin
         if (addr == 3'd6)      s = SEL_CTLALT;
         else if (addr == 3'd7) s = SEL_DRVADR;
         else                   s = SEL_NONE;   // R12: unused control-block slots
      end
      return s;
   endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
   import ata_tf_pkg::*;
(
   input  logic       cs0_n,
   input  logic       cs1_n,
   input  logic [2:0] addr,
   input  logic       rd,
   input  logic       wr,
   input  logic       busy,
   output tf_sel_e    sel,
   output logic       cb_wr,
   output logic       ctl_wr,
   output logic       prim_rd,
   output logic       data_rd
);

   logic in_cb;

   assign sel   = tf_decode(cs0_n, cs1_n, addr);
   assign in_cb = (sel != SEL_NONE) && (sel != SEL_CTLALT) && (sel != SEL_DRVADR);

   // R10: command-block writes dropped while busy; control always passes
   assign cb_wr   = wr && in_cb && !busy;
   assign ctl_wr  = wr && (sel == SEL_CTLALT);
   // R6: only the primary status read has a side effect on the interrupt
   assign prim_rd = rd && (sel == SEL_CMDST);
   assign data_rd = rd && (sel == SEL_DATA);

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
#(
   parameter int CYL_W = 10
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_def,
   input  tf_sel_e          sel,
   input  logic             cb_wr,
   input  logic             data_rd,
   input  logic [15:0]      wdata,
   input  logic             dev_data_load,
   input  logic [15:0]      dev_data_in,
   output logic [15:0]      data_q,
   output logic [7:0]       precomp_q,
   output logic [7:0]       scnt_q,
   output logic [7:0]       snum_q,
   output logic [CYL_W-1:0] cyl_q,
   output logic             drv_q,
   output logic [3:0]       head_q,
   output logic             cmd_stb,
   output logic [7:0]       cmd_code,
   output logic             data_wr_stb,
   output logic             data_rd_stb
);

   localparam int CYLH_W = CYL_W - 8;

   logic [7:0]        cyl_lo_q;
   logic [CYLH_W-1:0] cyl_hi_q;

   assign cyl_q = {cyl_hi_q, cyl_lo_q};

   // R13: data word shared by host writes and device loads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (cb_wr && sel == SEL_DATA) begin
         data_q <= wdata;
      end else if (dev_data_load) begin
         data_q <= dev_data_in;
      end
   end

   // R3 R4 R8 R9: byte registers with reset defaults
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         precomp_q <= '0;
         scnt_q    <= DEF_SCNT;
         snum_q    <= DEF_SNUM;
         cyl_lo_q  <= '0;
         cyl_hi_q  <= '0;
         drv_q     <= 1'b0;
         head_q    <= '0;
      end else if (hold_def) begin
         scnt_q    <= DEF_SCNT;
         snum_q    <= DEF_SNUM;
         cyl_lo_q  <= '0;
         cyl_hi_q  <= '0;
         drv_q     <= 1'b0;
         head_q    <= '0;
      end else if (cb_wr) begin
         case (sel)
            SEL_ERRPC: precomp_q <= wdata[7:0];   // R2
            SEL_SCNT:  scnt_q    <= wdata[7:0];
            SEL_SNUM:  snum_q    <= wdata[7:0];
            SEL_CYLL:  cyl_lo_q  <= wdata[7:0];
            SEL_CYLH:  cyl_hi_q  <= wdata[CYLH_W-1:0];
            SEL_DRVHD: begin
               drv_q  <= wdata[4];
               head_q <= wdata[3:0];
            end
            default: ;
         endcase
      end
   end

   // R5 R13: one-cycle strobes toward device logic
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb     <= 1'b0;
         cmd_code    <= '0;
         data_wr_stb <= 1'b0;
         data_rd_stb <= 1'b0;
      end else begin
         cmd_stb     <= cb_wr && (sel == SEL_CMDST);
         data_wr_stb <= cb_wr && (sel == SEL_DATA);
         data_rd_stb <= data_rd;
         if (cb_wr && sel == SEL_CMDST) cmd_code <= wdata[7:0];
      end
   end

endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status
   import ata_tf_pkg::*;
#(
   parameter int READY_DELAY = 16
)
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_rst,
   input  logic       cmd_acc,
   input  logic [7:0] dev_status_set,
   input  logic [7:0] dev_status_clr,
   input  logic       dev_err_load,
   input  logic [7:0] dev_err_in,
   input  logic       dev_cmd_done,
   input  logic       prim_rd,
   input  logic       nien,
   output logic [7:0] status_q,
   output logic [7:0] error_q,
   output logic       irq_q
);

   localparam int CNT_W = (READY_DELAY > 1) ? $clog2(READY_DELAY) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_DELAY - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             wait_q;
   logic [7:0]       st_next;

   always_comb begin
      st_next = (status_q & ~dev_status_clr) | dev_status_set;
      if (cmd_acc) st_next[ST_BSY] = 1'b1;    // R5
   end

   // R8 R9: reset hold, ready delay, then device-driven status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= ST_HW_RESET;
         error_q  <= '0;
         wait_q   <= 1'b1;
         cnt_q    <= '0;
      end else if (hold_rst) begin
         status_q <= (status_q & ~ST_RESET_CLR) | ST_HW_RESET;
         error_q  <= '0;
         wait_q   <= 1'b1;
         cnt_q    <= '0;
      end else if (wait_q) begin
         if (cnt_q == CNT_LAST) begin
            status_q[ST_BSY] <= 1'b0;
            status_q[ST_RDY] <= 1'b1;
            wait_q           <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         status_q <= st_next;
         if (dev_err_load) error_q <= dev_err_in;
      end
   end

   // R6 R7: pending interrupt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (hold_rst) begin
         irq_q <= 1'b0;
      end else if (dev_cmd_done && !nien) begin
         irq_q <= 1'b1;
      end else if (prim_rd) begin
         irq_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
   import ata_tf_pkg::*;
#(
   parameter int READY_DELAY = 16,
   parameter int CYL_W       = 10,
   parameter bit REG_RDATA   = 1'b0
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_cs0_n,
   input  logic             host_cs1_n,
   input  logic [2:0]       host_addr,
   input  logic             host_rd,
   input  logic             host_wr,
   input  logic [15:0]      host_wdata,
   output logic [15:0]      host_rdata,
   output logic             irq,
   output logic             soft_reset,
   input  logic [7:0]       dev_status_set,
   input  logic [7:0]       dev_status_clr,
   input  logic             dev_err_load,
   input  logic [7:0]       dev_err_in,
   input  logic             dev_data_load,
   input  logic [15:0]      dev_data_in,
   input  logic             dev_cmd_done,
   input  logic             dev_writing,
   output logic             cmd_stb,
   output logic [7:0]       cmd_code,
   output logic             data_wr_stb,
   output logic             data_rd_stb,
   output logic [15:0]      data_word,
   output logic [7:0]       precomp,
   output logic [7:0]       sect_cnt,
   output logic [7:0]       sect_num,
   output logic [CYL_W-1:0] cyl,
   output logic             drv_sel,
   output logic [3:0]       head
);

   localparam int CYLH_W = CYL_W - 8;

   if (READY_DELAY < 1) begin : g_bad_delay
      $error("READY_DELAY must be at least 1");
   end
   if (CYL_W < 9 || CYL_W > 16) begin : g_bad_cyl
      $error("CYL_W must lie in 9..16");
   end

   tf_sel_e     sel;
   logic        cb_wr, ctl_wr, prim_rd, data_rd;
   logic [7:0]  status_q, error_q;
   logic        nien_q, srst_q;
   logic [15:0] rd_mux;

   ata_tf_decode u_dec (
      .cs0_n   (host_cs0_n),
      .cs1_n   (host_cs1_n),
      .addr    (host_addr),
      .rd      (host_rd),
      .wr      (host_wr),
      .busy    (status_q[ST_BSY]),
      .sel     (sel),
      .cb_wr   (cb_wr),
      .ctl_wr  (ctl_wr),
      .prim_rd (prim_rd),
      .data_rd (data_rd)
   );

   ata_tf_regs #(.CYL_W(CYL_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .hold_def      (srst_q),
      .sel           (sel),
      .cb_wr         (cb_wr),
      .data_rd       (data_rd),
      .wdata         (host_wdata),
      .dev_data_load (dev_data_load),
      .dev_data_in   (dev_data_in),
      .data_q        (data_word),
      .precomp_q     (precomp),
      .scnt_q        (sect_cnt),
      .snum_q        (sect_num),
      .cyl_q         (cyl),
      .drv_q         (drv_sel),
      .head_q        (head),
      .cmd_stb       (cmd_stb),
      .cmd_code      (cmd_code),
      .data_wr_stb   (data_wr_stb),
      .data_rd_stb   (data_rd_stb)
   );

   ata_tf_status #(.READY_DELAY(READY_DELAY)) u_stat (
      .clk            (clk),
      .rst_n          (rst_n),
      .hold_rst       (srst_q),
      .cmd_acc        (cb_wr && sel == SEL_CMDST),
      .dev_status_set (dev_status_set),
      .dev_status_clr (dev_status_clr),
      .dev_err_load   (dev_err_load),
      .dev_err_in     (dev_err_in),
      .dev_cmd_done   (dev_cmd_done),
      .prim_rd        (prim_rd),
      .nien           (nien_q),
      .status_q       (status_q),
      .error_q        (error_q),
      .irq_q          (irq)
   );

   // R7 R8 R10: control register, accepted regardless of busy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nien_q <= 1'b0;
         srst_q <= 1'b0;
      end else if (ctl_wr) begin
         nien_q <= host_wdata[CTL_NIEN];
         srst_q <= host_wdata[CTL_SRST];
      end
   end

   assign soft_reset = srst_q;

   // R1 R2 R3 R4 R6 R11 R12: read path
   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_DATA:   rd_mux        = data_word;
         SEL_ERRPC:  rd_mux[7:0]   = error_q;
         SEL_SCNT:   rd_mux[7:0]   = sect_cnt;
         SEL_SNUM:   rd_mux[7:0]   = sect_num;
         SEL_CYLL:   rd_mux[7:0]   = cyl[7:0];
         SEL_CYLH:   rd_mux[CYLH_W-1:0] = cyl[CYL_W-1:8];
         SEL_DRVHD:  rd_mux[7:0]   = {DRVHD_FIXED, drv_sel, head};
         SEL_CMDST:  rd_mux[7:0]   = status_q;
         SEL_CTLALT: rd_mux[7:0]   = status_q;
         SEL_DRVADR: rd_mux[7:0]   = {1'b0, dev_writing, ~head, drv_sel, ~drv_sel};
         default:    rd_mux        = '0;
      endcase
   end

   if (REG_RDATA) begin : g_rdata_reg
      logic [15:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rdata_q <= '0;
         else if (host_rd) rdata_q <= rd_mux;
      end
      assign host_rdata = rdata_q;
   end else begin : g_rdata_comb
      assign host_rdata = rd_mux;
   end

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
   parameter bit REG_RDATA = 1'b0
)
(
   input logic        clk,
   input logic        rst_n,
   input logic        host_cs0_n,
   input logic        host_cs1_n,
   input logic [2:0]  host_addr,
   input logic        host_rd,
   input logic        host_wr,
   input logic [15:0] host_rdata,
   input logic        irq,
   input logic        dev_cmd_done,
   input logic        cmd_stb,
   input logic        soft_reset,
   input logic [7:0]  sect_cnt,
   input logic [7:0]  status_q,
   input logic        nien_q
);

   logic cb_sel, prim_rd, alt_rd, cmd_wr, scnt_wr;

   assign cb_sel  = !host_cs0_n && host_cs1_n;
   assign prim_rd = host_rd && cb_sel && host_addr == 3'd7;
   assign alt_rd  = host_rd && host_cs0_n && !host_cs1_n && host_addr == 3'd6;
   assign cmd_wr  = host_wr && cb_sel && host_addr == 3'd7;
   assign scnt_wr = host_wr && cb_sel && host_addr == 3'd2;

   p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_RDATA && cb_sel && host_addr != 3'd0) |-> host_rdata[15:8] == 8'h00);

   p_drvhd_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_RDATA && cb_sel && host_addr == 3'd6) |-> host_rdata[7:5] == 3'b101);

   p_cmd_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> $past(cmd_wr));

   p_prim_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_rd && !dev_cmd_done) |=> !irq);

   p_alt_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && alt_rd && !host_wr && !soft_reset) |=> irq);

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(dev_cmd_done && !nien_q));

   p_srst_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_reset && $past(soft_reset)) |-> status_q[7]);

   p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[7] && scnt_wr && !soft_reset) |=> $stable(sect_cnt));

endmodule

bind ata_taskfile ata_taskfile_chk #(.REG_RDATA(REG_RDATA)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_cs0_n   (host_cs0_n),
   .host_cs1_n   (host_cs1_n),
   .host_addr    (host_addr),
   .host_rd      (host_rd),
   .host_wr      (host_wr),
   .host_rdata   (host_rdata),
   .irq          (irq),
   .dev_cmd_done (dev_cmd_done),
   .cmd_stb      (cmd_stb),
   .soft_reset   (soft_reset),
   .sect_cnt     (sect_cnt),
   .status_q     (status_q),
   .nien_q       (nien_q)
);

// File: tb/ata_taskfile_test.sv
module ata_taskfile_test;

   localparam int CLK_PERIOD = 10;
   localparam int RDY        = 4;
   localparam int CYL_W      = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic             rst_n;
   logic             host_cs0_n, host_cs1_n;
   logic [2:0]       host_addr;
   logic             host_rd, host_wr;
   logic [15:0]      host_wdata, host_rdata;
   logic             irq, soft_reset;
   logic [7:0]       dev_status_set, dev_status_clr, dev_err_in;
   logic             dev_err_load, dev_data_load, dev_cmd_done, dev_writing;
   logic [15:0]      dev_data_in;
   logic             cmd_stb, data_wr_stb, data_rd_stb, drv_sel;
   logic [7:0]       cmd_code, precomp, sect_cnt, sect_num;
   logic [15:0]      data_word;
   logic [CYL_W-1:0] cyl;
   logic [3:0]       head;

   ata_taskfile #(.READY_DELAY(RDY), .CYL_W(CYL_W)) uut (
      .clk(clk), .rst_n(rst_n), .host_cs0_n(host_cs0_n), .host_cs1_n(host_cs1_n),
      .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .soft_reset(soft_reset), .dev_status_set(dev_status_set),
      .dev_status_clr(dev_status_clr), .dev_err_load(dev_err_load),
      .dev_err_in(dev_err_in), .dev_data_load(dev_data_load),
      .dev_data_in(dev_data_in), .dev_cmd_done(dev_cmd_done),
      .dev_writing(dev_writing), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
      .data_wr_stb(data_wr_stb), .data_rd_stb(data_rd_stb),
      .data_word(data_word), .precomp(precomp), .sect_cnt(sect_cnt),
      .sect_num(sect_num), .cyl(cyl), .drv_sel(drv_sel), .head(head)
   );

   typedef struct packed {
      logic        rd;      // 1 read-and-compare, 0 write
      logic        cs0n;
      logic        cs1n;
      logic [2:0]  addr;
      logic [15:0] data;
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 1'b1, 3'd2, 16'h0000, 16'h0001, 4'd9},   // R9 sector count default
      '{1'b1, 1'b0, 1'b1, 3'd3, 16'h0000, 16'h0001, 4'd9},   // R9 sector number default
      '{1'b1, 1'b0, 1'b1, 3'd4, 16'h0000, 16'h0000, 4'd9},   // R9 cylinder low default
      '{1'b1, 1'b0, 1'b1, 3'd5, 16'h0000, 16'h0000, 4'd9},   // R9 cylinder high default
      '{1'b1, 1'b0, 1'b1, 3'd6, 16'h0000, 16'h00A0, 4'd9},   // R9 drive/head default
      '{1'b1, 1'b0, 1'b1, 3'd1, 16'h0000, 16'h0000, 4'd9},   // R9 error default
      '{1'b1, 1'b0, 1'b1, 3'd7, 16'h0000, 16'h0040, 4'd6},   // R6 ready status
      '{1'b0, 1'b0, 1'b1, 3'd2, 16'h1255, 16'h0000, 4'd3},
      '{1'b1, 1'b0, 1'b1, 3'd2, 16'h0000, 16'h0055, 4'd3},   // R3 R1 upper byte dropped
      '{1'b0, 1'b0, 1'b1, 3'd3, 16'h00FE, 16'h0000, 4'd3},
      '{1'b1, 1'b0, 1'b1, 3'd3, 16'h0000, 16'h00FE, 4'd3},   // R3
      '{1'b0, 1'b0, 1'b1, 3'd4, 16'h0034, 16'h0000, 4'd3},
      '{1'b1, 1'b0, 1'b1, 3'd4, 16'h0000, 16'h0034, 4'd3},   // R3
      '{1'b0, 1'b0, 1'b1, 3'd5, 16'h00FF, 16'h0000, 4'd3},
      '{1'b1, 1'b0, 1'b1, 3'd5, 16'h0000, 16'h0003, 4'd3},   // R3 two bits kept
      '{1'b0, 1'b0, 1'b1, 3'd6, 16'h001B, 16'h0000, 4'd4},
      '{1'b1, 1'b0, 1'b1, 3'd6, 16'h0000, 16'h00BB, 4'd4},   // R4 slave, head 11
      '{1'b1, 1'b1, 1'b0, 3'd7, 16'h0000, 16'h0012, 4'd11},  // R11 slave, ~head
      '{1'b0, 1'b0, 1'b1, 3'd6, 16'h00E3, 16'h0000, 4'd4},
      '{1'b1, 1'b0, 1'b1, 3'd6, 16'h0000, 16'h00A3, 4'd4},   // R4 fixed bits hold
      '{1'b1, 1'b1, 1'b0, 3'd7, 16'h0000, 16'h0031, 4'd11},  // R11 master, ~head
      '{1'b0, 1'b0, 1'b1, 3'd0, 16'hBEEF, 16'h0000, 4'd1},
      '{1'b1, 1'b0, 1'b1, 3'd0, 16'h0000, 16'hBEEF, 4'd1},   // R1 full word
      '{1'b0, 1'b0, 1'b1, 3'd1, 16'h0077, 16'h0000, 4'd2},
      '{1'b1, 1'b0, 1'b1, 3'd1, 16'h0000, 16'h0000, 4'd2},   // R2 error untouched
      '{1'b1, 1'b1, 1'b0, 3'd6, 16'h0000, 16'h0040, 4'd6},   // R6 alternate status
      '{1'b0, 1'b0, 1'b0, 3'd2, 16'h0099, 16'h0000, 4'd12},
      '{1'b1, 1'b0, 1'b1, 3'd2, 16'h0000, 16'h0055, 4'd12},  // R12 both low ignored
      '{1'b1, 1'b1, 1'b1, 3'd2, 16'h0000, 16'h0000, 4'd12},  // R12 none selected
      '{1'b1, 1'b1, 1'b0, 3'd2, 16'h0000, 16'h0000, 4'd12},  // R12 empty slot
      '{1'b0, 1'b1, 1'b1, 3'd3, 16'h0011, 16'h0000, 4'd12},
      '{1'b1, 1'b0, 1'b1, 3'd3, 16'h0000, 16'h00FE, 4'd12}   // R12 both high ignored
   };

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic check(input string what, input int req,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual 0x%h expected 0x%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic c0, input logic c1, input logic [2:0] a,
                            input logic [15:0] d);
      @(negedge clk);
      host_cs0_n = c0; host_cs1_n = c1; host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_cs0_n = 1'b1; host_cs1_n = 1'b1;
   endtask

   task automatic bus_read(input logic c0, input logic c1, input logic [2:0] a,
                           output logic [15:0] v);
      @(negedge clk);
      host_cs0_n = c0; host_cs1_n = c1; host_addr = a; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0; host_cs0_n = 1'b1; host_cs1_n = 1'b1;
   endtask

   task automatic pulse_done();
      @(negedge clk); dev_cmd_done = 1'b1;
      @(negedge clk); dev_cmd_done = 1'b0;
   endtask

   task automatic dev_status(input logic [7:0] s, input logic [7:0] c);
      @(negedge clk); dev_status_set = s; dev_status_clr = c;
      @(negedge clk); dev_status_set = '0; dev_status_clr = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      rst_n = 1'b0;
      host_cs0_n = 1'b0; host_cs1_n = 1'b1; host_addr = 3'd7;
      host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
      dev_status_set = '0; dev_status_clr = '0; dev_err_load = 1'b0; dev_err_in = '0;
      dev_data_load = 1'b0; dev_data_in = '0; dev_cmd_done = 1'b0; dev_writing = 1'b0;

      // R9: reset state and ready delay after release
      repeat (3) @(negedge clk);
      check("status in reset", 9, host_rdata, 16'h0080);
      check("irq in reset", 9, {15'd0, irq}, 16'h0000);
      rst_n = 1'b1;
      repeat (RDY - 1) @(negedge clk);
      check("busy before delay", 9, host_rdata, 16'h0080);
      @(negedge clk);
      check("ready after delay", 9, host_rdata, 16'h0040);
      host_cs0_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            bus_read(VEC[i].cs0n, VEC[i].cs1n, VEC[i].addr, v);
            check($sformatf("vector %0d", i), int'(VEC[i].req), v, VEC[i].exp);
         end else begin
            bus_write(VEC[i].cs0n, VEC[i].cs1n, VEC[i].addr, VEC[i].data);
         end
      end
      check("precomp output", 2, {8'd0, precomp}, 16'h0077);   // R2

      // R13: data word strobes and device load
      bus_write(1'b0, 1'b1, 3'd0, 16'h1357);
      check("data_wr_stb", 13, {15'd0, data_wr_stb}, 16'h0001);
      check("data_word", 13, data_word, 16'h1357);
      @(negedge clk); dev_data_load = 1'b1; dev_data_in = 16'hA5C3;
      @(negedge clk); dev_data_load = 1'b0;
      bus_read(1'b0, 1'b1, 3'd0, v);
      check("device data read", 13, v, 16'hA5C3);
      check("data_rd_stb", 13, {15'd0, data_rd_stb}, 16'h0001);

      // R2: error byte from device
      @(negedge clk); dev_err_load = 1'b1; dev_err_in = 8'h04;
      @(negedge clk); dev_err_load = 1'b0;
      bus_read(1'b0, 1'b1, 3'd1, v);
      check("error read", 2, v, 16'h0004);

      // R6: device-driven status bits
      dev_status(8'h09, 8'h00);
      bus_read(1'b0, 1'b1, 3'd7, v);
      check("status set", 6, v, 16'h0049);
      dev_status(8'h00, 8'h09);

      // R5: command write
      bus_write(1'b0, 1'b1, 3'd7, 16'h0020);
      check("cmd_stb", 5, {15'd0, cmd_stb}, 16'h0001);
      check("cmd_code", 5, {8'd0, cmd_code}, 16'h0020);
      @(negedge clk);
      check("cmd_stb one cycle", 5, {15'd0, cmd_stb}, 16'h0000);
      bus_read(1'b0, 1'b1, 3'd7, v);
      check("busy after command", 5, v, 16'h00C0);

      // R10: busy blocks command block, not control
      bus_write(1'b0, 1'b1, 3'd2, 16'h0011);
      bus_read(1'b0, 1'b1, 3'd2, v);
      check("write while busy", 10, v, 16'h0055);
      bus_write(1'b1, 1'b0, 3'd6, 16'h0002);
      pulse_done();
      check("irq masked", 7, {15'd0, irq}, 16'h0000);   // R7 and R10
      bus_write(1'b1, 1'b0, 3'd6, 16'h0000);
      dev_status(8'h00, 8'h80);
      pulse_done();
      check("irq raised", 7, {15'd0, irq}, 16'h0001);   // R7

      // R6: alternate keeps, primary clears
      bus_read(1'b1, 1'b0, 3'd6, v);
      check("alt status value", 6, v, 16'h0040);
      check("irq after alt read", 6, {15'd0, irq}, 16'h0001);
      bus_read(1'b0, 1'b1, 3'd7, v);
      check("irq after primary read", 6, {15'd0, irq}, 16'h0000);

      // R8: software reset
      pulse_done();
      dev_status(8'h29, 8'h00);
      bus_write(1'b0, 1'b1, 3'd6, 16'h0017);
      bus_write(1'b1, 1'b0, 3'd6, 16'h0004);
      check("soft_reset bit", 8, {15'd0, soft_reset}, 16'h0001);
      @(negedge clk);
      check("irq dropped", 8, {15'd0, irq}, 16'h0000);
      bus_read(1'b0, 1'b1, 3'd7, v);
      check("status in srst", 8, v, 16'h00A0);
      bus_read(1'b0, 1'b1, 3'd2, v);
      check("sector count default", 8, v, 16'h0001);
      bus_read(1'b0, 1'b1, 3'd6, v);
      check("drive/head default", 8, v, 16'h00A0);
      bus_read(1'b0, 1'b1, 3'd1, v);
      check("error cleared", 8, v, 16'h0000);
      bus_write(1'b0, 1'b1, 3'd2, 16'h0055);
      bus_read(1'b0, 1'b1, 3'd2, v);
      check("write during srst", 10, v, 16'h0001);
      bus_write(1'b1, 1'b0, 3'd6, 16'h0000);
      host_cs0_n = 1'b1; host_cs1_n = 1'b0; host_addr = 3'd6;
      repeat (RDY - 1) @(negedge clk);
      check("busy before delay", 8, host_rdata, 16'h00A0);
      @(negedge clk);
      check("ready after delay", 8, host_rdata, 16'h0060);
      host_cs1_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule